// File: doc/BRIEF.md
# SMBus START/STOP Detector with Programmable Hold Guard

This block watches the two wires of an SMBus or I2C bus and reports bus conditions to the rest of a controller. It brings both lines into the system clock domain through a synchroniser chain. It finds edges by comparing each synchronised sample with the sample before it. It then emits a one-cycle `start_o` pulse for every START and a one-cycle `stop_o` pulse for every STOP.

Two lines with very different loading can let SCL fall slightly after SDA in the middle of an ordinary data bit, and that looks like a START. To reject such events, the block times how long SCL stays high after SDA falls. A START is reported only if that time reaches a threshold. The threshold is one system clock by default. A two-bit guard setting can extend it by 2, 4 or 8 clocks. Shifting data and matching addresses are left to neighbouring logic.

Top module: `smb_start_detect`

## Requirements
- R1: While `rst_n` is low, and on every clock after reset while both lines stay high, `start_o` and `stop_o` are 0. The synchroniser stages reset to the idle-high level.
- R2: With `gap_sel_i` = 00, SDA falling while SCL is high, followed by SCL falling one or more samples later, gives exactly one `start_o` pulse.
  - The pulse appears on the third rising clock edge, counting the edge that first samples SCL low as the first.
- R3: Intervals are counted in clock samples, from the first sample with SDA low to the first sample with SCL low. The required interval depends on `gap_sel_i`:
  - 00 requires 1 sample.
  - 01 requires 3 samples.
  - 10 requires 5 samples.
  - 11 requires 9 samples.
  - An interval equal to the required value is accepted.
- R4: An SCL fall whose interval is below the required value produces no `start_o` pulse. This includes an interval exactly one sample short.
- R5: If SDA returns high while SCL is still high, the pending START qualification is dropped. No `start_o` follows a later SCL fall.
- R6: SDA rising while SCL is high on both the current and the previous sample gives exactly one `stop_o` pulse, with the same latency as R2.
- R7: SDA and SCL falling on the same sample never produce a `start_o` pulse, whatever the setting.
- R8: SDA changes while SCL is low produce neither `start_o` nor `stop_o`.
- R9: `start_o` and `stop_o` are never high together, and neither stays high for two consecutive cycles.
- R10: The interval counter saturates at its maximum. An SCL fall any number of samples beyond the threshold is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sda_i | input | 1 | Raw SDA line level |
| scl_i | input | 1 | Raw SCL line level |
| gap_sel_i | input | 2 | Hold guard setting; must stay stable while a START is pending |
| start_o | output | 1 | One-cycle START indication |
| stop_o | output | 1 | One-cycle STOP indication |

## Verification
For every guard setting, the bench places the SCL fall exactly one sample before the threshold and exactly on it. A comparison that is off by one, or that counts from the wrong edge, shows up as a START that is either lost or falsely accepted. Coincident falls, a cancelled START, data toggles under low SCL and a very late SCL fall are also driven. A design that armed on simultaneous edges, kept a stale qualification after a STOP, decoded data bits as bus conditions, or wrapped its counter would emit a pulse that the reference model does not predict. A behavioural model built on timestamps predicts both outputs every cycle, so a wrong latency is also caught.

// File: rtl/smb_start_pkg.sv
package smb_start_pkg;

   typedef enum logic [1:0] {
      GAP_NONE  = 2'b00,
      GAP_SHORT = 2'b01,
      GAP_MID   = 2'b10,
      GAP_LONG  = 2'b11
   } gap_sel_e;

   typedef struct packed {
      logic level;
      logic fall;
      logic rise;
   } line_evt_t;

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
   parameter int   STAGES = 2,
   parameter logic INIT   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= INIT;
               else        chain[0] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= INIT;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/smb_line_edge.sv
module smb_line_edge
   import smb_start_pkg::*;
#(
   parameter logic INIT = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      lvl_i,
   output logic      prev_o,
   output line_evt_t evt_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_o <= INIT;
      else        prev_o <= lvl_i;
   end

   always_comb begin
      evt_o.level = lvl_i;
      evt_o.fall  = prev_o & ~lvl_i;
      evt_o.rise  = ~prev_o & lvl_i;
   end
endmodule

// File: rtl/smb_start_qual.sv
module smb_start_qual
   import smb_start_pkg::*;
#(
   parameter int BASE_GAP = 1,
   parameter int EXT_A    = 2,
   parameter int EXT_B    = 4,
   parameter int EXT_C    = 8
) (
   input  logic      clk,
   input  logic      rst_n,
   input  line_evt_t sda_evt_i,
   input  line_evt_t scl_evt_i,
   input  gap_sel_e  gap_sel_i,
   output logic      start_o,
   output logic      stop_o
);
   localparam int MAX_GAP = BASE_GAP + EXT_C;
   localparam int CNT_W   = $clog2(MAX_GAP + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_GAP);

   logic [CNT_W-1:0] elapsed;
   logic [CNT_W-1:0] need;
   logic             armed;
   logic             scl_steady_hi;
   logic             arm_hit;
   logic             stop_hit;

   always_comb begin
      unique case (gap_sel_i)
         GAP_NONE:  need = CNT_W'(BASE_GAP);
         GAP_SHORT: need = CNT_W'(BASE_GAP + EXT_A);
         GAP_MID:   need = CNT_W'(BASE_GAP + EXT_B);
         default:   need = CNT_W'(BASE_GAP + EXT_C);
      endcase
   end

   assign scl_steady_hi = scl_evt_i.level & ~scl_evt_i.rise;
   assign arm_hit       = sda_evt_i.fall & scl_steady_hi;
   assign stop_hit      = sda_evt_i.rise & scl_steady_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed   <= 1'b0;
         elapsed <= '0;
         start_o <= 1'b0;
         stop_o  <= 1'b0;
      end else begin
         start_o <= 1'b0;
         stop_o  <= stop_hit;
         if (armed) begin
            if (scl_evt_i.fall) begin
               armed   <= 1'b0;
               start_o <= (elapsed >= need);
            end else if (sda_evt_i.rise) begin
               armed <= 1'b0;
            end else if (elapsed != CNT_MAX) begin
               elapsed <= elapsed + 1'b1;
            end
         end
         if (arm_hit) begin
            armed   <= 1'b1;
            elapsed <= CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/smb_start_detect.sv
module smb_start_detect
   import smb_start_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int BASE_GAP    = 1,
   parameter int EXT_A       = 2,
   parameter int EXT_B       = 4,
   parameter int EXT_C       = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sda_i,
   input  logic       scl_i,
   input  logic [1:0] gap_sel_i,
   output logic       start_o,
   output logic       stop_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (BASE_GAP < 1) begin : g_bad_base
         $error("BASE_GAP must be at least 1");
      end
      if (!(EXT_A <= EXT_B && EXT_B <= EXT_C && EXT_A >= 0)) begin : g_bad_ext
         $error("guard extensions must be non-negative and ascending");
      end
   endgenerate

   logic      sda_s, scl_s;
   logic      sda_p, scl_p;
   line_evt_t sda_evt, scl_evt;

   smb_line_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s));
   smb_line_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s));

   smb_line_edge #(.INIT(1'b1)) u_edge_sda (
      .clk(clk), .rst_n(rst_n), .lvl_i(sda_s), .prev_o(sda_p), .evt_o(sda_evt));
   smb_line_edge #(.INIT(1'b1)) u_edge_scl (
      .clk(clk), .rst_n(rst_n), .lvl_i(scl_s), .prev_o(scl_p), .evt_o(scl_evt));

   smb_start_qual #(
      .BASE_GAP(BASE_GAP), .EXT_A(EXT_A), .EXT_B(EXT_B), .EXT_C(EXT_C)
   ) u_qual (
      .clk(clk), .rst_n(rst_n),
      .sda_evt_i(sda_evt), .scl_evt_i(scl_evt),
      .gap_sel_i(gap_sel_e'(gap_sel_i)),
      .start_o(start_o), .stop_o(stop_o));
endmodule

// File: rtl/smb_start_detect_chk.sv
module smb_start_detect_chk (
   input logic clk,
   input logic rst_n,
   input logic start_o,
   input logic stop_o,
   input logic sda_s,
   input logic sda_p,
   input logic scl_s,
   input logic scl_p
);
   // R1
   always @(posedge clk) begin
      if (!rst_n) begin
         reset_quiet_chk: assert (!start_o && !stop_o);
      end
   end

   // R9
   excl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_o && stop_o));

   // R9
   start_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> !start_o);

   // R9
   stop_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_o |=> !stop_o);

   // R2
   start_on_scl_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> $past(scl_p && !scl_s));

   // R8
   start_sda_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> $past(!sda_s && !sda_p));

   // R6
   stop_on_sda_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_o |-> $past(!sda_p && sda_s && scl_s && scl_p));
endmodule

bind smb_start_detect smb_start_detect_chk chk_i (
   .clk(clk), .rst_n(rst_n), .start_o(start_o), .stop_o(stop_o),
   .sda_s(sda_s), .sda_p(sda_p), .scl_s(scl_s), .scl_p(scl_p));

// File: tb/smb_start_detect_tb.sv
`timescale 1ns/1ps
module smb_start_detect_tb_top;
   localparam int SYNC = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sda_i = 1'b1;
   logic       scl_i = 1'b1;
   logic [1:0] gap_sel_i = 2'b00;
   logic       start_o, stop_o;

   int checks = 0;
   int fails  = 0;
   int start_seen = 0;
   int stop_seen  = 0;
   string cur_req = "R1";
   bit done = 1'b0;

   always #4 clk = ~clk;

   smb_start_detect dut_i (
      .clk(clk), .rst_n(rst_n), .sda_i(sda_i), .scl_i(scl_i),
      .gap_sel_i(gap_sel_i), .start_o(start_o), .stop_o(stop_o));

   // behavioural reference model: timestamps and a latency queue
   bit   st_q[$];
   bit   sp_q[$];
   bit   m_sda_prev, m_scl_prev, m_armed;
   int   m_t0, m_cyc;
   bit   exp_start, exp_stop;

   function automatic int need_for(input logic [1:0] s);
      case (s)
         2'b00: return 1;
         2'b01: return 3;
         2'b10: return 5;
         default: return 9;
      endcase
   endfunction

   always @(posedge clk) begin
      bit e_st, e_sp;
      if (!rst_n) begin
         st_q = {};
         sp_q = {};
         for (int i = 0; i < SYNC; i++) begin
            st_q.push_back(1'b0);
            sp_q.push_back(1'b0);
         end
         m_sda_prev = 1'b1; m_scl_prev = 1'b1; m_armed = 1'b0;
         m_cyc = 0; m_t0 = 0;
         exp_start = 1'b0; exp_stop = 1'b0;
      end else begin
         e_st = 1'b0;
         e_sp = 1'b0;
         if (m_armed && m_scl_prev && !scl_i) begin
            m_armed = 1'b0;
            e_st = ((m_cyc - m_t0) >= need_for(gap_sel_i));
         end else if (m_armed && !m_sda_prev && sda_i) begin
            m_armed = 1'b0;
         end
         if (!m_sda_prev && sda_i && m_scl_prev && scl_i) e_sp = 1'b1;
         if (m_sda_prev && !sda_i && m_scl_prev && scl_i) begin
            m_armed = 1'b1;
            m_t0 = m_cyc;
         end
         st_q.push_back(e_st);
         sp_q.push_back(e_sp);
         exp_start = st_q.pop_front();
         exp_stop  = sp_q.pop_front();
         m_sda_prev = sda_i;
         m_scl_prev = scl_i;
         m_cyc++;
      end
   end

   // every-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         checks++;
         if (start_o !== exp_start) begin
            fails++;
            $display("FAIL %s start_o cycle compare: actual %b expected %b", cur_req, start_o, exp_start);
         end
         checks++;
         if (stop_o !== exp_stop) begin
            fails++;
            $display("FAIL %s stop_o cycle compare: actual %b expected %b", cur_req, stop_o, exp_stop);
         end
         if (start_o === 1'b1) start_seen++;
         if (stop_o === 1'b1)  stop_seen++;
      end
   end

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check_int(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic clear_counts();
      @(negedge clk);
      start_seen = 0;
      stop_seen  = 0;
   endtask

   // SDA falls, SCL falls d samples later, then a STOP returns the bus to idle
   task automatic try_start(input logic [1:0] sel, input int d, input int exp_st, input string req);
      cur_req   = req;
      gap_sel_i = sel;
      wait_n(4);
      clear_counts();
      sda_i = 1'b0;
      if (d > 0) wait_n(d);
      scl_i = 1'b0;
      wait_n(5);
      check_int(req, $sformatf("start count sel=%0d gap=%0d", sel, d), start_seen, exp_st);
      scl_i = 1'b1;
      wait_n(3);
      sda_i = 1'b1;
      wait_n(5);
      check_int("R6", "stop count after release", stop_seen, 1);
   endtask

   initial begin
      wait_n(3);
      checks++;
      if (start_o !== 1'b0 || stop_o !== 1'b0) begin
         fails++;
         $display("FAIL R1 outputs in reset: actual %b%b expected 00", start_o, stop_o);
      end
      rst_n = 1'b1;
      cur_req = "R1";
      clear_counts();
      wait_n(8);
      check_int("R1", "idle start count", start_seen, 0);
      check_int("R1", "idle stop count", stop_seen, 0);

      // R2: default setting, various gaps
      try_start(2'b00, 1, 1, "R2");
      try_start(2'b00, 3, 1, "R2");

      // R3 / R4: threshold and one short, every setting
      for (int s = 0; s < 4; s++) begin
         try_start(2'(s), need_for(2'(s)) - 1, 0, (s == 0) ? "R7" : "R4");
         try_start(2'(s), need_for(2'(s)), 1, "R3");
      end

      // R7: simultaneous falls with a long guard
      try_start(2'b11, 0, 0, "R7");

      // R10: very late SCL fall with longest guard
      try_start(2'b11, 20, 1, "R10");

      // R5: cancelled START, then a late SCL fall
      cur_req = "R5";
      gap_sel_i = 2'b00;
      wait_n(4);
      clear_counts();
      sda_i = 1'b0;
      wait_n(3);
      sda_i = 1'b1;
      wait_n(4);
      scl_i = 1'b0;
      wait_n(5);
      check_int("R5", "start after cancel", start_seen, 0);
      check_int("R6", "stop from cancel", stop_seen, 1);
      scl_i = 1'b1;
      wait_n(4);

      // R8: data toggles while SCL is low
      try_start(2'b00, 2, 1, "R2");
      cur_req = "R8";
      sda_i = 1'b0; scl_i = 1'b1;
      wait_n(2);
      scl_i = 1'b0;
      wait_n(4);
      clear_counts();
      sda_i = 1'b1;
      wait_n(2);
      scl_i = 1'b1;
      wait_n(3);
      scl_i = 1'b0;
      wait_n(2);
      sda_i = 1'b0;
      wait_n(2);
      scl_i = 1'b1;
      wait_n(3);
      scl_i = 1'b0;
      wait_n(2);
      sda_i = 1'b1;
      wait_n(5);
      check_int("R8", "start during data", start_seen, 0);
      check_int("R8", "stop during data", stop_seen, 0);
      sda_i = 1'b0;
      wait_n(2);
      scl_i = 1'b1;
      wait_n(2);
      sda_i = 1'b1;
      wait_n(6);

      // R9: back-to-back conditions keep pulses single
      cur_req = "R9";
      clear_counts();
      sda_i = 1'b0;
      wait_n(1);
      sda_i = 1'b1;
      wait_n(1);
      sda_i = 1'b0;
      wait_n(1);
      scl_i = 1'b0;
      wait_n(5);
      check_int("R9", "start after quick stop", start_seen, 1);
      check_int("R9", "quick stop count", stop_seen, 1);
      scl_i = 1'b1;
      wait_n(2);
      sda_i = 1'b1;
      wait_n(6);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule